// File: doc/BRIEF.md
# I2C Chunked Burst Sequencer

This block sits between a processor register bus and an I2C master byte engine. It moves a message in chunks of up to 32 bytes with no processor action per byte. Software fills a transmit FIFO or sets a receive length, then starts the chunk. The sequencer issues the address and every data byte to the byte engine. When the chunk is done it raises one chunk-done flag.

A message longer than one chunk is sent as several chunks. The first chunk opens the bus with a write to the start register, which issues START and the address. Each later chunk is started by a pulse on the continue bit and sends data only, with no new START. STOP follows a chunk only when the matching end bit was set before that chunk began. Otherwise the bus stays held for the next chunk. A NACK on the address or on a written byte ends the transfer early with STOP and raises both the done flag and the NACK flag.

The byte-engine command path is valid/ready. A command stays valid with stable op, data and ack fields until the engine takes it with `cmd_ready`, and the engine may hold `cmd_ready` low for as long as it needs. After each accepted command the sequencer waits for exactly one `rsp_valid` pulse before it issues the next command, so at most one command is outstanding. The response path has no back-pressure. Register accesses take one cycle. Read data is combinational from `reg_addr`.

Top module: `i2c_burst_seq`

Register map (`reg_addr`):
- 0 control: bit0 burst-mode enable, bit1 stop-after-read arm, bit2 stop-after-write arm, bit3 continue pulse (write-only, reads 0).
- 1 start: write `{addr[6:0], rd}` to open a transfer.
- 2 flags: bit0 chunk done, bit1 NACK. Writing a 1 to a bit clears that bit.
- 3 flush: bit0 empties the TX FIFO, bit1 empties the RX FIFO.
- 4 TX push.
- 5 RX pop.
- 6 TX length minus one.
- 7 RX length minus one.

Command ops on `cmd_op`: 0 address, 1 write byte, 2 read byte, 3 STOP.

## Requirements
- R1: After reset, `cmd_valid`, `irq_done` and `irq_nack` are 0, the flags register reads 0, and popping the empty RX FIFO reads 0.
- R2: A start write while control bit0 is 0 issues no command.
- R3: A start write with burst mode enabled issues an address command carrying the start byte, then N+1 data commands, where N is the length register for the direction (TX for a write, RX for a read). Write commands carry the TX FIFO bytes in push order. Read commands carry data 0.
- R4: The chunk-done flag sets when a chunk finishes. Writing 1 to a flags bit clears only that bit.
- R5: A chunk that ends without an armed stop leaves the bus held and issues no STOP. A later continue pulse sends the next chunk's data with no address command. Start writes are ignored while the bus is held, and continue pulses are ignored while it is free.
- R6: If the end bit for the direction is set when a chunk starts, a STOP command follows the last data byte of that chunk.
- R7: On read commands `cmd_ack`=1 means the master ACKs the byte. Only the last byte of a read chunk with an armed stop has `cmd_ack`=0.
- R8: A NACK response to the address or to a written byte ends the transfer with STOP and no further data. Both `irq_done` and `irq_nack` are set.
- R9: A push to a full TX FIFO (32 entries) is dropped. A pop from an empty RX FIFO returns 0.
- R10: Writing flush bits empties the selected FIFO, and earlier contents are discarded.
- R11: While `cmd_valid` is high and `cmd_ready` is low, the command is held stable. Back-pressure does not change the command sequence.
- R12: Received bytes are popped in arrival order, across chunk boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (pops RX at address 5) |
| reg_addr | input | 3 | register address |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data |
| cmd_valid | output | 1 | command valid |
| cmd_ready | input | 1 | engine takes command |
| cmd_op | output | 2 | command op |
| cmd_data | output | 8 | address byte or write data |
| cmd_ack | output | 1 | ACK to send on a read byte |
| rsp_valid | input | 1 | command completed |
| rsp_data | input | 8 | received byte |
| rsp_nack | input | 1 | slave NACKed address or write byte |
| irq_done | output | 1 | chunk-done flag |
| irq_nack | output | 1 | NACK flag |

## Verification
The bench attacks the chunk boundaries. If a held bus got a STOP, or a later chunk got a fresh address, the logged op stream would not match. A design that latched the end bit too late, or ACKed the wrong read byte, would show it in the STOP and ack fields. NACKs are injected on the address and on a middle write byte: a design that kept sending data, or set only one flag, is caught. Overfilling the TX FIFO, flushing with stale data present, popping an empty RX FIFO, and stalling `cmd_ready` each expose a design that lets old or extra bytes through.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  typedef enum logic [1:0] {OP_ADDR = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3} op_e;
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_START = 3'd1;
  localparam logic [2:0] A_FLAGS = 3'd2;
  localparam logic [2:0] A_FLUSH = 3'd3;
  localparam logic [2:0] A_TXD   = 3'd4;
  localparam logic [2:0] A_RXD   = 3'd5;
  localparam logic [2:0] A_TXLEN = 3'd6;
  localparam logic [2:0] A_RXLEN = 3'd7;
endpackage

// File: rtl/i2cb_fifo.sv
module i2cb_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr;
  logic          full, empty;

  assign count = wr_ptr - rd_ptr;
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign head  = empty ? '0 : mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push && !full) wr_ptr <= wr_ptr + 1'b1;
      if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !flush) mem[wr_ptr[AW-1:0]] <= wdata;
  end
endmodule

// File: rtl/i2cb_regs.sv
module i2cb_regs
  import i2cb_pkg::*;
#(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [7:0]    rx_head,
  input  logic          done_set,
  input  logic          nack_set,
  output logic          burst_en,
  output logic          end_rd,
  output logic          end_wr,
  output logic          start_pulse,
  output logic [7:0]    start_byte,
  output logic          cont_pulse,
  output logic [LW-1:0] tx_len,
  output logic [LW-1:0] rx_len,
  output logic          flush_tx,
  output logic          flush_rx,
  output logic          tx_push,
  output logic          rx_pop,
  output logic          flag_done,
  output logic          flag_nack
);
  logic wr_ctrl, wr_flags;

  assign wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  assign wr_flags = reg_wr && reg_addr == A_FLAGS;
  assign flush_tx = reg_wr && reg_addr == A_FLUSH && reg_wdata[0];
  assign flush_rx = reg_wr && reg_addr == A_FLUSH && reg_wdata[1];
  assign tx_push  = reg_wr && reg_addr == A_TXD;
  assign rx_pop   = reg_rd && reg_addr == A_RXD;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = {5'd0, end_wr, end_rd, burst_en};
      A_FLAGS: reg_rdata = {6'd0, flag_nack, flag_done};
      A_RXD:   reg_rdata = rx_head;
      A_TXLEN: reg_rdata = 8'(tx_len);
      A_RXLEN: reg_rdata = 8'(rx_len);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_en    <= 1'b0;
      end_rd      <= 1'b0;
      end_wr      <= 1'b0;
      start_pulse <= 1'b0;
      start_byte  <= '0;
      cont_pulse  <= 1'b0;
      tx_len      <= '0;
      rx_len      <= '0;
      flag_done   <= 1'b0;
      flag_nack   <= 1'b0;
    end else begin
      start_pulse <= reg_wr && reg_addr == A_START;
      cont_pulse  <= wr_ctrl && reg_wdata[3];
      if (reg_wr && reg_addr == A_START) start_byte <= reg_wdata;
      if (wr_ctrl) begin
        burst_en <= reg_wdata[0];
        end_rd   <= reg_wdata[1];
        end_wr   <= reg_wdata[2];
      end
      if (reg_wr && reg_addr == A_TXLEN) tx_len <= reg_wdata[LW-1:0];
      if (reg_wr && reg_addr == A_RXLEN) rx_len <= reg_wdata[LW-1:0];
      flag_done <= done_set | (flag_done & ~(wr_flags & reg_wdata[0]));
      flag_nack <= nack_set | (flag_nack & ~(wr_flags & reg_wdata[1]));
    end
  end
endmodule

// File: rtl/i2cb_seq.sv
module i2cb_seq
  import i2cb_pkg::*;
#(
  parameter int LW = 5,
  localparam int CW = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          burst_en,
  input  logic          end_rd,
  input  logic          end_wr,
  input  logic          start_pulse,
  input  logic [7:0]    start_byte,
  input  logic          cont_pulse,
  input  logic [LW-1:0] tx_len,
  input  logic [LW-1:0] rx_len,
  input  logic [7:0]    tx_head,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_op,
  output logic [7:0]    cmd_data,
  output logic          cmd_ack,
  input  logic          rsp_valid,
  input  logic          rsp_nack,
  output logic          tx_pop,
  output logic          rx_push,
  output logic          done_set,
  output logic          nack_set,
  output logic          bus_held,
  output logic          arm_stop,
  output logic          nack_seen
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WADDR, S_DATA, S_WDATA, S_STOP, S_WSTOP} st_e;
  st_e          st;
  logic         rd_q;
  logic [7:0]   addr_q;
  logic [CW-1:0] left_q;
  logic         last, hs, wr_nack, go_start, go_cont;
  logic [CW-1:0] len_start, len_cont;
  op_e          op;

  assign last      = (left_q == CW'(1));
  assign hs        = cmd_valid && cmd_ready;
  assign wr_nack   = !rd_q && rsp_nack;
  assign go_start  = burst_en && start_pulse && !bus_held;
  assign go_cont   = burst_en && cont_pulse && bus_held;
  assign len_start = {1'b0, start_byte[0] ? rx_len : tx_len} + CW'(1);
  assign len_cont  = {1'b0, rd_q ? rx_len : tx_len} + CW'(1);

  always_comb begin
    op       = OP_ADDR;
    cmd_data = '0;
    case (st)
      S_ADDR:  cmd_data = addr_q;
      S_DATA: begin
        op       = rd_q ? OP_READ : OP_WRITE;
        cmd_data = rd_q ? 8'd0 : tx_head;
      end
      S_STOP:  op = OP_STOP;
      default: op = OP_ADDR;
    endcase
  end

  assign cmd_op    = op;
  assign cmd_valid = (st == S_ADDR) || (st == S_DATA) || (st == S_STOP);
  assign cmd_ack   = (st == S_DATA) && rd_q && !(last && arm_stop);
  assign tx_pop    = hs && st == S_DATA && !rd_q;
  assign rx_push   = rsp_valid && st == S_WDATA && rd_q;
  assign done_set  = rsp_valid && ((st == S_WSTOP) ||
                     (st == S_WDATA && !wr_nack && last && !arm_stop));
  assign nack_set  = rsp_valid && st == S_WSTOP && nack_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rd_q      <= 1'b0;
      addr_q    <= '0;
      left_q    <= '0;
      bus_held  <= 1'b0;
      arm_stop  <= 1'b0;
      nack_seen <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (go_start) begin
            rd_q      <= start_byte[0];
            addr_q    <= start_byte;
            arm_stop  <= start_byte[0] ? end_rd : end_wr;
            left_q    <= len_start;
            nack_seen <= 1'b0;
            bus_held  <= 1'b1;
            st        <= S_ADDR;
          end else if (go_cont) begin
            arm_stop <= rd_q ? end_rd : end_wr;
            left_q   <= len_cont;
            st       <= S_DATA;
          end
        end
        S_ADDR:  if (hs) st <= S_WADDR;
        S_WADDR: if (rsp_valid) begin
          if (rsp_nack) begin
            nack_seen <= 1'b1;
            st        <= S_STOP;
          end else begin
            st <= S_DATA;
          end
        end
        S_DATA:  if (hs) st <= S_WDATA;
        S_WDATA: if (rsp_valid) begin
          if (wr_nack) begin
            nack_seen <= 1'b1;
            st        <= S_STOP;
          end else begin
            left_q <= left_q - CW'(1);
            if (!last)         st <= S_DATA;
            else if (arm_stop) st <= S_STOP;
            else               st <= S_IDLE;
          end
        end
        S_STOP:  if (hs) st <= S_WSTOP;
        S_WSTOP: if (rsp_valid) begin
          bus_held <= 1'b0;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_burst_seq.sv
module i2c_burst_seq #(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH),
  localparam int CW = LW + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [1:0] cmd_op,
  output logic [7:0] cmd_data,
  output logic       cmd_ack,
  input  logic       rsp_valid,
  input  logic [7:0] rsp_data,
  input  logic       rsp_nack,
  output logic       irq_done,
  output logic       irq_nack
);
  logic          burst_en, end_rd, end_wr, start_pulse, cont_pulse;
  logic [7:0]    start_byte, tx_head, rx_head;
  logic [LW-1:0] tx_len, rx_len;
  logic          flush_tx, flush_rx, tx_push, rx_pop, tx_pop, rx_push;
  logic          done_set, nack_set, bus_held, arm_stop, nack_seen;
  logic [CW-1:0] tx_count, rx_count;

  i2cb_regs #(.LW(LW)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .rx_head, .done_set, .nack_set, .burst_en, .end_rd, .end_wr,
    .start_pulse, .start_byte, .cont_pulse, .tx_len, .rx_len,
    .flush_tx, .flush_rx, .tx_push, .rx_pop,
    .flag_done(irq_done), .flag_nack(irq_nack)
  );

  i2cb_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n, .flush(flush_tx), .push(tx_push), .wdata(reg_wdata),
    .pop(tx_pop), .head(tx_head), .count(tx_count)
  );

  i2cb_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n, .flush(flush_rx), .push(rx_push), .wdata(rsp_data),
    .pop(rx_pop), .head(rx_head), .count(rx_count)
  );

  i2cb_seq #(.LW(LW)) u_seq (
    .clk, .rst_n, .burst_en, .end_rd, .end_wr, .start_pulse, .start_byte,
    .cont_pulse, .tx_len, .rx_len, .tx_head,
    .cmd_valid, .cmd_ready, .cmd_op, .cmd_data, .cmd_ack,
    .rsp_valid, .rsp_nack, .tx_pop, .rx_push, .done_set, .nack_set,
    .bus_held, .arm_stop, .nack_seen
  );
endmodule

// File: rtl/i2cb_chk.sv
module i2cb_chk #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [7:0]    cmd_data,
  input logic          irq_done,
  input logic          irq_nack,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          bus_held,
  input logic          arm_stop,
  input logic          nack_seen
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_data)); // R11
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(DEPTH)); // R9
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH)); // R9
  AST_NACK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_nack) |-> irq_done); // R8
  AST_STOP_JUSTIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd3 |-> arm_stop || nack_seen); // R6
  AST_CMD_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> bus_held); // R5
endmodule

bind i2c_burst_seq i2cb_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_data(cmd_data), .irq_done(irq_done), .irq_nack(irq_nack),
  .tx_count(tx_count), .rx_count(rx_count), .bus_held(bus_held),
  .arm_stop(arm_stop), .nack_seen(nack_seen)
);

// File: tb/i2c_burst_seq_test.sv
module i2c_burst_seq_test;
  localparam logic [1:0] OA = 2'd0, OW = 2'd1, OR = 2'd2, OS = 2'd3;
  // bit6 = read, bits5:0 = byte count
  localparam logic [6:0] VEC [6] = '{7'h02, 7'h42, 7'h20, 7'h60, 7'h07, 7'h45};

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic cmd_valid, cmd_ready, cmd_ack;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;
  logic rsp_valid, rsp_nack;
  logic [7:0] rsp_data;
  logic irq_done, irq_nack;

  int nchk = 0, nfail = 0;
  logic [1:0] lop [128];
  logic [7:0] ldat [128];
  logic lack [128];
  int ln = 0, rdcnt = 0, wrcnt = 0, nack_wr_at = 0, pend = 0, bpc = 0;
  bit addr_nack = 0, bp = 0;
  logic [7:0] sv_data;
  logic sv_nack;

  always #5 clk = ~clk;

  i2c_burst_seq uut (.*);

  // byte engine model
  initial begin
    cmd_ready = 1; rsp_valid = 0; rsp_data = 0; rsp_nack = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rsp_valid = 1; rsp_data = sv_data; rsp_nack = sv_nack;
        end
      end else begin
        if (bp && cmd_valid && bpc < 2) begin cmd_ready = 0; bpc++; end
        else cmd_ready = 1;
        if (cmd_valid && cmd_ready) begin
          bpc = 0;
          lop[ln] = cmd_op; ldat[ln] = cmd_data; lack[ln] = cmd_ack; ln++;
          sv_data = 0; sv_nack = 0;
          case (cmd_op)
            OA: sv_nack = addr_nack;
            OW: begin wrcnt++; sv_nack = (wrcnt == nack_wr_at); end
            OR: begin sv_data = 8'hA0 + 8'(rdcnt); rdcnt++; end
            default: ;
          endcase
          pend = 2;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!irq_done && t < 3000) begin @(negedge clk); t++; end
    chk(irq_done, req, irq_done, 1);
  endtask

  task automatic exp_op(input int i, input logic [1:0] op, input logic [7:0] d, input string req);
    chk(i < ln && lop[i] == op && ldat[i] == d, req, {lop[i], ldat[i]}, {op, d});
  endtask

  task automatic fresh();
    ln = 0; rdcnt = 0; wrcnt = 0; nack_wr_at = 0; addr_nack = 0;
    wr(3'd2, 8'h03); wr(3'd3, 8'h03);
  endtask

  initial begin
    logic [7:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!cmd_valid && !irq_done && !irq_nack, "R1 outputs", {cmd_valid, irq_done, irq_nack}, 0);
    rd(3'd2, v); chk(v == 0, "R1 flags", v, 0);
    rd(3'd5, v); chk(v == 0, "R1/R9 empty pop", v, 0);
    // R2 start ignored with burst mode off
    wr(3'd6, 8'd1); wr(3'd1, 8'h54);
    repeat (20) @(negedge clk);
    chk(ln == 0 && !irq_done, "R2 no command", ln, 0);

    // vector table: single armed chunks (R3 R6 R7 R12)
    foreach (VEC[k]) begin
      bit r;
      int n;
      r = VEC[k][6]; n = int'(VEC[k][5:0]);
      fresh();
      if (!r) for (int i = 0; i < n; i++) wr(3'd4, 8'h30 + 8'(i + k));
      wr(r ? 3'd7 : 3'd6, 8'(n - 1));
      wr(3'd0, 8'h07);
      wr(3'd1, {7'h2A, r});
      wait_done("R4 vector done");
      repeat (4) @(negedge clk);
      chk(!irq_nack, "R3 no nack", irq_nack, 0);
      chk(ln == n + 2, "R3 command count", ln, n + 2);
      exp_op(0, OA, {7'h2A, r}, "R3 address");
      for (int i = 0; i < n; i++) begin
        exp_op(1 + i, r ? OR : OW, r ? 8'h00 : 8'h30 + 8'(i + k), "R3 data");
        if (r) chk(lack[1 + i] == (i != n - 1), "R7 ack", lack[1 + i], i != n - 1);
      end
      exp_op(n + 1, OS, 8'h00, "R6 stop");
      if (r) for (int i = 0; i < n; i++) begin
        rd(3'd5, v); chk(v == 8'hA0 + 8'(i), "R12 rx order", v, 8'hA0 + 8'(i));
      end
    end

    // R5 continue ignored while bus is free
    fresh();
    wr(3'd0, 8'h09);
    repeat (20) @(negedge clk);
    chk(ln == 0 && !irq_done, "R5 cont when free", ln, 0);

    // R5 multi-chunk write, no START on second chunk
    fresh();
    for (int i = 0; i < 32; i++) wr(3'd4, 8'h80 + 8'(i));
    wr(3'd6, 8'd31); wr(3'd0, 8'h01); wr(3'd1, 8'h22);
    wait_done("R5 chunk1 done");
    repeat (4) @(negedge clk);
    chk(ln == 33 && lop[32] == OW, "R5 held no stop", ln, 33);
    wr(3'd2, 8'h01);
    wr(3'd1, 8'h22);
    repeat (20) @(negedge clk);
    chk(ln == 33 && !irq_done, "R5 start ignored while held", ln, 33);
    for (int i = 0; i < 8; i++) wr(3'd4, 8'h90 + 8'(i));
    wr(3'd6, 8'd7); wr(3'd0, 8'h0D);
    wait_done("R5 chunk2 done");
    repeat (4) @(negedge clk);
    chk(ln == 42, "R5 chunk2 count", ln, 42);
    for (int i = 0; i < 8; i++) exp_op(33 + i, OW, 8'h90 + 8'(i), "R5 chunk2 data");
    exp_op(41, OS, 0, "R6 final stop");

    // R7 R12 multi-chunk read
    fresh();
    wr(3'd7, 8'd2); wr(3'd0, 8'h01); wr(3'd1, 8'h67);
    wait_done("R5 read chunk1");
    repeat (4) @(negedge clk);
    chk(ln == 4 && lack[3] == 1, "R7 unarmed last ack", lack[3], 1);
    wr(3'd2, 8'h01);
    wr(3'd7, 8'd1); wr(3'd0, 8'h0B);
    wait_done("R5 read chunk2");
    repeat (4) @(negedge clk);
    chk(ln == 7 && lop[4] == OR && lack[4] == 1 && lack[5] == 0 && lop[6] == OS,
        "R7 armed last nack", {lack[4], lack[5]}, 2'b10);
    for (int i = 0; i < 5; i++) begin
      rd(3'd5, v); chk(v == 8'hA0 + 8'(i), "R12 across chunks", v, 8'hA0 + 8'(i));
    end

    // R8 address NACK, R4 write-one-to-clear
    fresh();
    addr_nack = 1;
    wr(3'd4, 8'h11); wr(3'd4, 8'h12); wr(3'd6, 8'd1); wr(3'd0, 8'h05); wr(3'd1, 8'h44);
    wait_done("R8 addr nack done");
    repeat (4) @(negedge clk);
    chk(irq_nack && ln == 2 && lop[1] == OS, "R8 addr nack stop", {irq_nack, 8'(ln)}, 12'h102);
    wr(3'd2, 8'h01);
    rd(3'd2, v); chk(v == 8'h02, "R4 clear done only", v, 2);
    wr(3'd2, 8'h02);
    rd(3'd2, v); chk(v == 8'h00, "R4 clear nack", v, 0);

    // R8 write data NACK on second byte
    fresh();
    nack_wr_at = 2;
    for (int i = 0; i < 4; i++) wr(3'd4, 8'hC0 + 8'(i));
    wr(3'd6, 8'd3); wr(3'd0, 8'h05); wr(3'd1, 8'h44);
    wait_done("R8 data nack done");
    repeat (4) @(negedge clk);
    chk(irq_nack && ln == 4 && lop[3] == OS, "R8 data nack stop", ln, 4);

    // R9 push into full TX FIFO dropped
    fresh();
    for (int i = 0; i < 33; i++) wr(3'd4, 8'h40 + 8'(i));
    wr(3'd6, 8'd31); wr(3'd0, 8'h05); wr(3'd1, 8'h10);
    wait_done("R9 full done");
    repeat (4) @(negedge clk);
    chk(ln == 34, "R9 count", ln, 34);
    for (int i = 0; i < 32; i++) exp_op(1 + i, OW, 8'h40 + 8'(i), "R9 first 32 kept");

    // R10 TX flush discards old bytes
    fresh();
    for (int i = 0; i < 3; i++) wr(3'd4, 8'hE0 + 8'(i));
    wr(3'd3, 8'h01);
    wr(3'd4, 8'hF0); wr(3'd4, 8'hF1);
    wr(3'd6, 8'd1); wr(3'd0, 8'h05); wr(3'd1, 8'h10);
    wait_done("R10 done");
    repeat (4) @(negedge clk);
    exp_op(1, OW, 8'hF0, "R10 tx flush");
    exp_op(2, OW, 8'hF1, "R10 tx flush");

    // R10 RX flush
    fresh();
    wr(3'd7, 8'd1); wr(3'd0, 8'h03); wr(3'd1, 8'h11);
    wait_done("R10 rx done");
    wr(3'd3, 8'h02);
    rd(3'd5, v); chk(v == 0, "R10 rx flush", v, 0);

    // R11 back-pressure
    fresh();
    bp = 1;
    for (int i = 0; i < 4; i++) wr(3'd4, 8'h70 + 8'(i));
    wr(3'd6, 8'd3); wr(3'd0, 8'h05); wr(3'd1, 8'h5C);
    wait_done("R11 done");
    repeat (4) @(negedge clk);
    bp = 0;
    base = 0;
    chk(ln == 6, "R11 count", ln, 6);
    exp_op(base, OA, 8'h5C, "R11 addr");
    for (int i = 0; i < 4; i++) exp_op(1 + i, OW, 8'h70 + 8'(i), "R11 data");
    exp_op(5, OS, 0, "R11 stop");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule